// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block reads 16-bit words out of a three-wire serial EEPROM that has a 6-bit word address. It drives four pins: chip select, serial clock, serial data toward the memory, and serial data back from it. A host presents a byte address and a byte count, then pulses `start` while `ready` is high. The block halves the byte address to get the first word address. It then runs one complete transaction per word and hands each word back as two bytes on `byte_out`, each byte marked by `byte_valid`. The low byte comes first.

Every transaction is built from clock phases, and each phase lasts a programmable number of system clocks. A single phase counter walks through a fixed layout for each word:

- select, then one dummy clock pulse with chip select high;
- the 3-bit read opcode `110` and the 6-bit word address, with each bit held for three phases (clock low, clock high, clock low);
- sixteen read bits, each made of a clock-high phase followed by a clock-low phase;
- a deselect phase.

Data coming back from the memory passes through a two-flop synchronizer and is sampled on the last system clock of each clock-high phase. A request with bad arguments is refused with a one-cycle error pulse.

Top module: `sprom_word_reader`

## Requirements
- R1: `ready` is 1 only while idle. `start` is taken only when `ready` is 1. While idle, `ee_cs` and `ee_sk` are 0. `ready` drops in the cycle after an accepted start.
- R2: A start is refused when `byte_addr` is odd, when `byte_cnt` is odd, or when `byte_cnt` is zero. For a refused start, `err` is 1 for exactly the next cycle, `ready` stays 1, and the memory pins stay low.
- R3: Each word takes 64 phases, numbered 0 to 63. Phase 0 has chip select low. Phase 1 raises chip select. Phase 2 is a clock-high dummy pulse with chip select high. Phase 3 has the clock low again. The clock is never high while chip select is low.
- R4: After the dummy pulse, nine bits go out MSB first: the opcode `110`, then the 6-bit word address. Each bit takes three phases (4+3k to 6+3k), and the clock is high only in the middle phase. The data line stays stable for all three phases.
- R5: Phases 31 to 62 clock in 16 bits, MSB first. Odd phases have the clock high and even phases have it low. `ee_do` goes through a two-flop synchronizer and is sampled on the last cycle of each clock-high phase. The memory therefore has up to L-4 cycles of slack.
- R6: Phase 63 drops chip select. In the next cycle `byte_out` carries bits 7:0 of the word with `byte_valid` high. In the cycle after that it carries bits 15:8 with `byte_valid` high. `byte_out` is 0 whenever `byte_valid` is 0.
- R7: The first word address is `byte_addr[6:1]`. `byte_cnt/2` words are read, and the word address rises by one per word, wrapping from 63 to 0.
- R8: A phase lasts `phase_len` system clocks, captured at the accepted start. A value of 0 selects 50 clocks, which is 1 us at 50 MHz.
- R9: `done` is 1 for a single cycle, in the cycle after the high byte of the last word. `ready` returns in the cycle after that.
- R10: Let L be the phase length, n the word count, and cycle 0 the cycle after the accepting edge. Word w runs in cycles w·(64L+2) to w·(64L+2)+64L+1. Its bytes fall in its last two cycles, and `done` falls in cycle n·(64L+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a read; taken when ready is 1 |
| byte_addr | input | 7 | First byte address; must be even |
| byte_cnt | input | 8 | Number of bytes; must be even and nonzero |
| phase_len | input | 16 | System clocks per serial clock phase; 0 selects the default |
| ready | output | 1 | Idle and able to take a start |
| err | output | 1 | One-cycle pulse on a refused start |
| byte_out | output | 8 | Returned byte |
| byte_valid | output | 1 | byte_out holds a byte this cycle |
| done | output | 1 | One-cycle pulse after the last byte |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
Every result has a fixed cycle, counted from the cycle after the accepting edge:

- the chip select and clock levels follow from phase number o/L at offset o inside the word;
- the two bytes appear at offsets 64L and 64L+1;
- `done` appears at n·(64L+2);
- `err` appears one cycle after a refused start.

The bench steps through every cycle at the falling edge and compares each of these outputs with the value that its timeline gives for that cycle. A behavioural memory model watches the pins, checks the opcode, address and clock count of each transaction, and drives read data one cycle after each rising clock. Under that model, phases of 4 or more clocks have to return exactly the stored words.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    parameter int ADDR_W   = 6;
    parameter int DATA_W   = 16;
    parameter int CNT_W    = 8;
    parameter int DIV_W    = 16;
    parameter int BYTE_W   = 8;
    parameter int OPC_W    = 3;
    parameter logic [OPC_W-1:0] OPC_READ = 3'b110;

    localparam int FRAME_W  = OPC_W + ADDR_W;
    localparam int P_CMD0   = 4;
    localparam int P_DATA0  = P_CMD0 + 3 * FRAME_W;
    localparam int P_DESEL  = P_DATA0 + 2 * DATA_W;
    localparam int N_PHASES = P_DESEL + 1;
    localparam int PH_W     = $clog2(N_PHASES);
    localparam int BADDR_W  = ADDR_W + 1;
    localparam int WCNT_W   = CNT_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_EMIT_LO,
        ST_EMIT_HI,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
        logic smp;
    } pins_t;

    // Pin levels for one phase of a word transaction.
    function automatic pins_t phase_pins(input logic [PH_W-1:0] idx,
                                         input logic [ADDR_W-1:0] waddr);
        pins_t r;
        int p;
        int k;
        logic [FRAME_W-1:0] frame;
        logic [FRAME_W-1:0] sh;
        r     = '0;
        p     = int'(idx);
        frame = {OPC_READ, waddr};
        sh    = '0;
        if (p == 0 || p >= P_DESEL) begin
            r.cs = 1'b0;
        end else if (p < P_CMD0) begin
            r.cs = 1'b1;
            r.sk = (p == 2);
        end else if (p < P_DATA0) begin
            k    = p - P_CMD0;
            sh   = frame >> (FRAME_W - 1 - k / 3);
            r.cs = 1'b1;
            r.di = sh[0];
            r.sk = ((k % 3) == 1);
        end else begin
            k     = p - P_DATA0;
            r.cs  = 1'b1;
            r.sk  = ((k % 2) == 0);
            r.smp = r.sk;
        end
        return r;
    endfunction

endpackage

// File: rtl/sprom_phase_timer.sv
module sprom_phase_timer
    import sprom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sprom_sync.sv
module sprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= 1'b0;
        end else begin
            chain[0] <= d;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= 1'b0;
            end else begin
                chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sprom_shifter.sv
module sprom_shifter
    import sprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (en) begin
            word <= {word[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
    import sprom_pkg::*;
#(
    parameter int PHASE_DEFAULT = 50,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BADDR_W-1:0] byte_addr,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic [DIV_W-1:0]   phase_len,
    output logic               ready,
    output logic               err,
    output logic [BYTE_W-1:0]  byte_out,
    output logic               byte_valid,
    output logic               done,
    output logic               ee_cs,
    output logic               ee_sk,
    output logic               ee_di,
    input  logic               ee_do
);
    localparam logic [DIV_W-1:0] LEN_DEF = DIV_W'(PHASE_DEFAULT);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(P_DESEL);

    state_e              state;
    logic [PH_W-1:0]     phase_idx;
    logic [ADDR_W-1:0]   waddr;
    logic [WCNT_W-1:0]   words_left;
    logic [DIV_W-1:0]    len_q;
    logic                err_q;
    logic                run;
    logic                tick;
    logic                do_sync;
    logic                smp_en;
    logic                bad_req;
    logic [DATA_W-1:0]   word;
    pins_t               pins;

    assign run     = (state == ST_RUN);
    assign bad_req = byte_addr[0] | byte_cnt[0] | (byte_cnt == '0);
    assign pins    = phase_pins(phase_idx, waddr);
    assign smp_en  = run & tick & pins.smp;

    sprom_phase_timer u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .len (len_q),
        .tick(tick)
    );

    sprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (ee_do),
        .q  (do_sync)
    );

    sprom_shifter u_shift (
        .clk (clk),
        .rst (rst),
        .en  (smp_en),
        .din (do_sync),
        .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            phase_idx  <= '0;
            waddr      <= '0;
            words_left <= '0;
            len_q      <= LEN_DEF;
            err_q      <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (bad_req) begin
                            err_q <= 1'b1;
                        end else begin
                            len_q      <= (phase_len == '0) ? LEN_DEF : phase_len;
                            waddr      <= byte_addr[BADDR_W-1:1];
                            words_left <= byte_cnt[CNT_W-1:1];
                            phase_idx  <= '0;
                            state      <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (phase_idx == PH_LAST) begin
                            state <= ST_EMIT_LO;
                        end else begin
                            phase_idx <= phase_idx + 1'b1;
                        end
                    end
                end
                ST_EMIT_LO: begin
                    state <= ST_EMIT_HI;
                end
                ST_EMIT_HI: begin
                    waddr      <= waddr + 1'b1;
                    words_left <= words_left - 1'b1;
                    phase_idx  <= '0;
                    state      <= (words_left == WCNT_W'(1)) ? ST_FIN : ST_RUN;
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        byte_out = '0;
        if (state == ST_EMIT_LO) begin
            byte_out = word[BYTE_W-1:0];
        end else if (state == ST_EMIT_HI) begin
            byte_out = word[DATA_W-1:BYTE_W];
        end
    end

    assign byte_valid = (state == ST_EMIT_LO) || (state == ST_EMIT_HI);
    assign done       = (state == ST_FIN);
    assign ready      = (state == ST_IDLE);
    assign err        = err_q;
    assign ee_cs      = run & pins.cs;
    assign ee_sk      = run & pins.sk;
    assign ee_di      = run & pins.di;
endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic err,
    input logic byte_valid,
    input logic done,
    input logic ee_cs,
    input logic ee_sk
);
    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!ee_cs && !ee_sk));                              // R1

    AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        err |-> ready);                                             // R2

    AST_CLOCK_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);                                           // R3

    AST_DESELECT_BEFORE_BYTES: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_valid) |-> $past(!ee_cs));                       // R6

    AST_TWO_BYTES_ONLY: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && $past(byte_valid)) |-> ##1 !byte_valid);     // R6

    AST_BYTES_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !ready);                                     // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R9

    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);                                            // R9
endmodule

bind sprom_word_reader sprom_word_reader_chk chk_i (.*);

// File: tb/sprom_word_reader_tb_top.sv
module sprom_word_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  byte_addr = '0;
    logic [7:0]  byte_cnt = '0;
    logic [15:0] phase_len = '0;
    logic        ready, err, byte_valid, done, ee_cs, ee_sk, ee_di;
    logic [7:0]  byte_out;
    logic        ee_do;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sprom_word_reader dut_i (
        .clk(clk), .rst(rst), .start(start), .byte_addr(byte_addr),
        .byte_cnt(byte_cnt), .phase_len(phase_len), .ready(ready), .err(err),
        .byte_out(byte_out), .byte_valid(byte_valid), .done(done),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] rom_word(input int a);
        return 16'((a * 2909) ^ 23190);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural memory: captures command on rising clocks, returns data one cycle later.
    logic       prev_sk, prev_cs;
    int         edges;
    logic [2:0] m_cmd;
    logic [5:0] m_adr;
    logic [5:0] exp_waddr;
    logic       dev_do;
    assign ee_do = dev_do;

    always @(posedge clk) begin
        int n;
        logic [15:0] w;
        if (rst) begin
            prev_sk <= 1'b0; prev_cs <= 1'b0; edges <= 0;
            m_cmd <= '0; m_adr <= '0; dev_do <= 1'b0;
        end else begin
            prev_sk <= ee_sk;
            prev_cs <= ee_cs;
            if (ee_cs && !prev_cs) begin
                edges <= 0; m_cmd <= '0; m_adr <= '0; dev_do <= 1'b0;
            end else if (ee_cs && ee_sk && !prev_sk) begin
                n = edges + 1;
                edges <= n;
                if (n >= 2 && n <= 4) m_cmd <= {m_cmd[1:0], ee_di};
                if (n >= 5 && n <= 10) m_adr <= {m_adr[4:0], ee_di};
                if (n >= 11 && n <= 26) begin
                    w = rom_word(int'(m_adr));
                    dev_do <= w[26 - n];
                end else begin
                    dev_do <= 1'b0;
                end
            end
            if (!ee_cs && prev_cs) begin
                // R4: opcode 110, address, and 1+9+16 rising clocks per word
                chk(m_cmd == 3'b110, "R4", "opcode", int'(m_cmd), 6);
                chk(m_adr == exp_waddr, "R4", "word address", int'(m_adr), int'(exp_waddr));
                chk(edges == 26, "R5", "rising clocks per word", edges, 26);
                exp_waddr <= exp_waddr + 1'b1;
            end
        end
    end

    task automatic read_run(input int addr, input int cnt, input int len);
        int L, n, F, w, o, p;
        logic exp_cs, exp_sk, exp_valid;
        logic [15:0] rw;
        logic [7:0] exp_byte;
        L = (len == 0) ? 50 : len;   // R8: zero selects 50 clocks
        n = cnt / 2;
        F = 64 * L + 2;
        @(negedge clk);
        exp_waddr = 6'(addr / 2);
        byte_addr = 7'(addr); byte_cnt = 8'(cnt); phase_len = 16'(len);
        chk(ready == 1'b1, "R1", "ready before start", int'(ready), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= n * F + 1; c++) begin
            w = c / F;
            o = c % F;
            exp_cs = 1'b0; exp_sk = 1'b0;
            if (w < n && o < 64 * L) begin
                p = o / L;
                exp_cs = !(p == 0 || p == 63);
                exp_sk = (p == 2) || (p >= 4 && p <= 30 && ((p - 4) % 3) == 1)
                      || (p >= 31 && p <= 62 && (p % 2) == 1);
            end
            exp_valid = (w < n) && (o == 64 * L || o == 64 * L + 1);
            rw = rom_word((addr / 2 + w) % 64);
            exp_byte = !exp_valid ? 8'h00 : (o == 64 * L) ? rw[7:0] : rw[15:8];
            chk(ee_cs == exp_cs, "R3", "cs level (R8 phase length)", int'(ee_cs), int'(exp_cs));
            chk(ee_sk == exp_sk, "R3", "sk level (R8 phase length)", int'(ee_sk), int'(exp_sk));
            chk(byte_valid == exp_valid, "R10", "byte_valid timing", int'(byte_valid), int'(exp_valid));
            chk(byte_out == exp_byte, "R6", "byte value (R5 data)", int'(byte_out), int'(exp_byte));
            chk(done == (c == n * F), "R9", "done", int'(done), int'(c == n * F));
            chk(ready == (c > n * F), "R1", "ready", int'(ready), int'(c > n * F));
            if (c < n * F + 1) @(negedge clk);
        end
        // R7: one transaction per word, address wrapping modulo 64
        chk(exp_waddr == 6'((addr / 2 + n) % 64), "R7", "words transferred",
            int'(exp_waddr), (addr / 2 + n) % 64);
    endtask

    task automatic bad_run(input int addr, input int cnt);
        @(negedge clk);
        byte_addr = 7'(addr); byte_cnt = 8'(cnt); phase_len = 16'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R2", "err pulse", int'(err), 1);
        chk(ready == 1'b1, "R2", "ready kept", int'(ready), 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(err == 1'b0, "R2", "err one cycle", int'(err), 0);
            chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R2", "pins idle", int'(ee_cs), 0);
            chk(ready == 1'b1, "R2", "ready idle", int'(ready), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_waddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1, "R1", "reset ready", int'(ready), 1);
        chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R1", "reset pins", int'(ee_cs), 0);
        chk(byte_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "reset strobes",
            int'(byte_valid), 0);
        bad_run(5, 4);    // R2 odd address
        bad_run(4, 3);    // R2 odd count
        bad_run(4, 0);    // R2 zero count
        read_run(0, 2, 4);
        read_run(10, 6, 5);
        read_run(124, 8, 4);   // R7 wrap 62,63,0,1
        read_run(80, 2, 0);    // R8 default phase length
        read_run(38, 4, 7);
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule